// File: doc/BRIEF.md
# Slice-Addressed Register File

This block is a small synchronous register file. It holds an array of full-width words, but every access moves one narrow slice of a word. A write places one slice of data into one word. Each of the two read ports returns one slice of the word at its own address. A single slice select chooses the slice for the write and for both reads.

Word 0 is a hardwired zero register. It holds no storage. Any write aimed at it is dropped, and any read of it returns zero, even before the first reset. Reads are combinational and have no bypass: a read of the word being written in the same cycle returns the value from before the clock edge. Reset is synchronous and active low, and it wins over a write presented in the same cycle.

Top module: `slice_regfile`

## Requirements
- R1: The array holds 16 words of 32 bits. Each word has four 8-bit slices. A 2-bit `slice_sel` value k selects bits [8k+7:8k] of a word.
- R2: Each of the two read ports returns, in the same cycle, the slice picked by `slice_sel` from the word at that port's own 4-bit address. No register sits on the read path.
- R3: A read of address 0 returns 8'h00 on either port at all times. This includes the time before reset has ever been asserted.
- R4: A write to address 0 has no effect, whatever the level of `wr_en`.
- R5: While `wr_en` is low, no stored bit changes at a rising clock edge.
- R6: A write with `wr_en` high and a non-zero address stores `wr_data` into the selected slice of the addressed word at the rising edge. Every other slice of every word keeps its value.
- R7: When `rst_n` is sampled low at a rising edge, every word reads back as zero from the next cycle on.
- R8: A read of the word being written in the same cycle returns the value stored before the edge. There is no write-through.
- R9: A write presented in a cycle where `rst_n` is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Word address of the write |
| slice_sel | input | 2 | Slice select shared by the write and both reads |
| wr_data | input | 8 | Slice data to write |
| rd_addr_a | input | 4 | Word address of read port A |
| rd_addr_b | input | 4 | Word address of read port B |
| rd_data_a | output | 8 | Slice read from port A |
| rd_data_b | output | 8 | Slice read from port B |

## Verification
Directed cases fill one word slice by slice and read every slice back, which separates the slice positions from one another. They also write to address 0, pulse `wr_en` low, and present a write in the same cycle as reset. A long random run mixes writes, reset pulses and independent addresses on the two read ports. In that run a read often hits the word being written in the same cycle, which is what reveals an unwanted bypass. Because the reference model stores only the slice that was written, the random run also catches a write that touches a neighbouring slice or word.

// File: rtl/slrf_pkg.sv
package slrf_pkg;
  localparam int unsigned SLRF_WORDS   = 16;
  localparam int unsigned SLRF_WORD_W  = 32;
  localparam int unsigned SLRF_SLICE_W = 8;
  localparam int unsigned SLRF_RD_PORTS = 2;
endpackage

// File: rtl/slrf_wdec.sv
module slrf_wdec #(
  parameter int unsigned WORDS  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [WORDS-1:1]  hit
);
  // Word 0 has no decode line, so writes aimed at it go nowhere.
  for (genvar w = 1; w < WORDS; w++) begin : g_dec
    assign hit[w] = wr_en && (wr_addr == ADDR_W'(w));
  end
endmodule

// File: rtl/slrf_word.sv
module slrf_word #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned SLICES  = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_hit,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [SLICE_W-1:0]        wr_data,
  output logic [SLICES*SLICE_W-1:0] word_q
);
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic               slice_we;
    logic               slice_ld;
    logic [SLICE_W-1:0] slice_d;
    logic [SLICE_W-1:0] slice_q;

    assign slice_we = wr_hit && (wr_sel == SEL_W'(s));
    assign slice_ld = !rst_n || slice_we;

    always_comb begin
      if (!rst_n) slice_d = '0;
      else        slice_d = wr_data;
    end

    always_ff @(posedge clk) begin
      if (slice_ld) slice_q <= slice_d;
    end

    assign word_q[s*SLICE_W +: SLICE_W] = slice_q;
  end
endmodule

// File: rtl/slrf_rport.sv
module slrf_rport #(
  parameter int unsigned WORDS   = 16,
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned SLICES  = 4,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [WORDS-1:0][SLICES*SLICE_W-1:0] words,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [SEL_W-1:0]                     sel,
  output logic [SLICE_W-1:0]                   slice
);
  logic [SLICES*SLICE_W-1:0] word_pick;
  logic [SLICE_W-1:0]        slice_pick;

  always_comb begin
    word_pick  = words[addr];
    slice_pick = word_pick[sel*SLICE_W +: SLICE_W];
    if (addr == '0) slice = '0;
    else            slice = slice_pick;
  end
endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
  import slrf_pkg::*;
#(
  parameter int unsigned WORDS   = SLRF_WORDS,
  parameter int unsigned WORD_W  = SLRF_WORD_W,
  parameter int unsigned SLICE_W = SLRF_SLICE_W,
  localparam int unsigned ADDR_W = $clog2(WORDS),
  localparam int unsigned SLICES = WORD_W / SLICE_W,
  localparam int unsigned SEL_W  = $clog2(SLICES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SEL_W-1:0]   slice_sel,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr_a,
  input  logic [ADDR_W-1:0]  rd_addr_b,
  output logic [SLICE_W-1:0] rd_data_a,
  output logic [SLICE_W-1:0] rd_data_b
);
  logic [WORDS-1:1]                   wr_hit;
  logic [WORDS-1:0][WORD_W-1:0]       words;
  logic [SLRF_RD_PORTS-1:0][ADDR_W-1:0]  rd_addr;
  logic [SLRF_RD_PORTS-1:0][SLICE_W-1:0] rd_data;

  slrf_wdec #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_wdec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .hit     (wr_hit)
  );

  // Word 0 is a constant, never storage.
  assign words[0] = '0;

  for (genvar w = 1; w < WORDS; w++) begin : g_word
    slrf_word #(.SLICE_W(SLICE_W), .SLICES(SLICES), .SEL_W(SEL_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[w]),
      .wr_sel  (slice_sel),
      .wr_data (wr_data),
      .word_q  (words[w])
    );
  end

  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;

  for (genvar p = 0; p < SLRF_RD_PORTS; p++) begin : g_rd
    slrf_rport #(
      .WORDS(WORDS), .SLICE_W(SLICE_W), .SLICES(SLICES),
      .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_rport (
      .words (words),
      .addr  (rd_addr[p]),
      .sel   (slice_sel),
      .slice (rd_data[p])
    );
  end

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];
endmodule

// File: rtl/slice_regfile_chk.sv
module slice_regfile_chk #(
  parameter int unsigned WORDS   = 16,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned SEL_W   = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [SEL_W-1:0]             slice_sel,
  input logic [SLICE_W-1:0]           wr_data,
  input logic [ADDR_W-1:0]            rd_addr_a,
  input logic [ADDR_W-1:0]            rd_addr_b,
  input logic [SLICE_W-1:0]           rd_data_a,
  input logic [SLICE_W-1:0]           rd_data_b,
  input logic [WORDS-1:0][WORD_W-1:0] store
);
  // R3
  zero_word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr_a == '0) |-> (rd_data_a == '0)) and ((rd_addr_b == '0) |-> (rd_data_b == '0)));

  // R4
  zero_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr == '0) |=> (store[0] == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store));

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0)) |=>
      (((rd_addr_a == $past(wr_addr)) && (slice_sel == $past(slice_sel)))
        ? (rd_data_a == $past(wr_data)) : 1'b1));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> ((rd_data_a == '0) && (rd_data_b == '0)));

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (((rd_addr_b == $past(rd_addr_b)) && (slice_sel == $past(slice_sel)))
      ? (rd_data_b == $past(rd_data_b)) : 1'b1));
endmodule

bind slice_regfile slice_regfile_chk #(
  .WORDS(WORDS), .WORD_W(WORD_W), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .slice_sel (slice_sel),
  .wr_data   (wr_data),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b),
  .store     (words)
);

// File: tb/slice_regfile_test.sv
module slice_regfile_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [1:0] slice_sel;
  logic [7:0] wr_data;
  logic [3:0] rd_addr_a;
  logic [3:0] rd_addr_b;
  logic [7:0] rd_data_a;
  logic [7:0] rd_data_b;

  int total;
  int bad;
  logic [7:0] model [16][4];

  slice_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .slice_sel(slice_sel), .wr_data(wr_data), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] expect_rd(input logic [3:0] a, input logic [1:0] s);
    if (a == 4'd0) return 8'h00;
    return model[a][s];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      for (int w = 0; w < 16; w++)
        for (int s = 0; s < 4; s++) model[w][s] = 8'h00;
    end else if (wr_en && wr_addr != 4'd0) begin
      model[wr_addr][slice_sel] = wr_data;
    end
  endtask

  // Drive at the falling edge, check the combinational reads mid low phase,
  // then let the rising edge commit and mirror it in the model.
  task automatic step(input logic rn, input logic we, input logic [3:0] wa,
                      input logic [1:0] ss, input logic [7:0] wd,
                      input logic [3:0] ra, input logic [3:0] rb, input string req);
    @(negedge clk);
    rst_n = rn; wr_en = we; wr_addr = wa; slice_sel = ss; wr_data = wd;
    rd_addr_a = ra; rd_addr_b = rb;
    #2;
    if (req != "") begin
      check(req, rd_data_a, expect_rd(ra, ss));
      check(req, rd_data_b, expect_rd(rb, ss));
    end
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] ra, rb, wa;
    logic [1:0] ss;
    string tag;
    void'($urandom(32'd1234));
    total = 0; bad = 0;
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < 4; s++) model[w][s] = 8'h00;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; slice_sel = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;

    // R3: word 0 reads zero before any reset
    #2;
    check("R3", rd_data_a, 8'h00);
    check("R3", rd_data_b, 8'h00);
    step(1, 1, 4'd0, 2'd1, 8'hAA, 4'd0, 4'd0, "R3");

    // R7: reset, then every word reads zero
    step(0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, "");
    for (int w = 0; w < 16; w += 2)
      for (int s = 0; s < 4; s++) step(1, 0, 0, 2'(s), 0, 4'(w), 4'(w + 1), "R7");

    // R1: fill word 5 slice by slice, read each slice back
    for (int s = 0; s < 4; s++) step(1, 1, 4'd5, 2'(s), 8'(8'h11 * (s + 1)), 4'd0, 4'd0, "");
    for (int s = 0; s < 4; s++) begin
      step(1, 0, 0, 2'(s), 0, 4'd5, 4'd5, "R1");
      check("R1", rd_data_a, 8'(8'h11 * (s + 1)));
    end

    // R4: writes to word 0, enabled and not
    step(1, 1, 4'd0, 2'd2, 8'h5A, 4'd0, 4'd5, "R4");
    step(1, 0, 4'd0, 2'd2, 8'hA5, 4'd0, 4'd5, "R4");
    step(1, 0, 0, 2'd2, 0, 4'd0, 4'd5, "R4");

    // R5: enable low with changing data and address
    step(1, 0, 4'd5, 2'd0, 8'hEE, 4'd5, 4'd9, "");
    step(1, 0, 4'd5, 2'd0, 8'hEE, 4'd5, 4'd9, "R5");
    check("R5", rd_data_a, 8'h11);

    // R8: same-cycle read of the word being written returns old data
    step(1, 1, 4'd5, 2'd3, 8'h77, 4'd5, 4'd5, "R8");
    check("R8", rd_data_a, 8'h44);
    step(1, 0, 0, 2'd3, 0, 4'd5, 4'd5, "R6");
    check("R6", rd_data_a, 8'h77);

    // R9: write in a reset cycle is lost
    step(0, 1, 4'd7, 2'd1, 8'h3C, 4'd7, 4'd7, "");
    step(1, 0, 0, 2'd1, 0, 4'd7, 4'd5, "R9");
    check("R9", rd_data_a, 8'h00);

    // R2/R6/R8: random traffic with independent read ports
    for (int i = 0; i < 4000; i++) begin
      wa = 4'($urandom_range(0, 15));
      ss = 2'($urandom_range(0, 3));
      ra = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15));
      rb = 4'($urandom_range(0, 15));
      if (ra == 4'd0) tag = "R3";
      else if (ra == wa) tag = "R8";
      else if (rb != ra) tag = "R2";
      else tag = "R6";
      step(($urandom_range(0, 59) != 0), ($urandom_range(0, 2) != 0), wa, ss,
           8'($urandom), ra, rb, tag);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule